// File: doc/BRIEF.md
# One-Time-Programmable Memory Command Engine

This engine runs after the device has been selected on a single-wire bus. It turns a stream of received bytes into accesses to a small one-time-programmable store. The store has a 128-byte data array in four 32-byte pages and an 8-byte status array. The host sends a command byte and a two-byte address, low byte first. For writes it also sends one data byte. The engine answers with an 8-bit CRC, and the host uses that CRC to check what the engine received. The engine then either streams stored bytes back to the host or waits for a program pulse.

Programming can only clear bits. After each program pulse the engine sends back the stored byte so the host can verify it. It then moves on to the next address, and the host may send another data byte without sending a new header. Status byte 0 holds one write-protect flag per data page. Status byte 7 always reads zero. The other status bytes are plain storage.

The byte interfaces are single-cycle strobes. A receive strobe delivers one byte. A transmit request is answered one cycle later with a byte on the transmit port. A bus-reset strobe and a program-pulse strobe complete the interface.

Top module: `otp_cmd_engine`

## Requirements
- R1: The accepted command codes are 0Fh (write data), 55h (write status), F0h (read data to the end), C3h (read data with a CRC after each page) and AAh (read status). After the header, and after the data byte for writes, the first transmit request returns the CRC of those bytes. The CRC uses polynomial x^8+x^5+x^4+1, starts from zero and takes each byte least significant bit first. Any other command byte leaves the engine answering FFh until a bus reset.
- R2: For command 0Fh, the received low address byte is masked to its low 7 bits and the high address byte is taken as 00h. The CRC and the target address are both built from these masked values.
- R3: The data and status cells start at FFh. A program pulse replaces the target cell with the cell value AND the buffered byte.
- R4: After a program pulse, the next transmit request returns the target cell's stored value and advances the address. Data addresses wrap modulo 128 and status addresses modulo 8. The next CRC equals the new low address byte loaded as the CRC state, followed by the next data byte shifted in.
- R5: When bit p (p = 0..3) of status byte 0 is 0, data page p (addresses 32p to 32p+31) is never changed by a program pulse. It can still be read.
- R6: Status byte 7 always reads 00h, and writes to it have no effect. Status bytes 1 to 6 are ordinary storage, and their contents do not change how data writes behave.
- R7: After the header CRC, command F0h returns data bytes from the start address through address 127. Its next answer is the CRC of those bytes, starting from zero, and every answer after that is FFh.
- R8: Command C3h returns data bytes to the end of the current page and then the CRC of the bytes read in that page, starting from zero. It then continues at the next page. After the CRC of page 3, every answer is FFh.
- R9: Command AAh returns status bytes from the start address through byte 7. It then returns their CRC, starting from zero, and after that FFh.
- R10: A bus-reset strobe aborts any command. The next received byte is then taken as a new command, and a pending write is dropped.
- R11: A program pulse has no effect unless a write's CRC has already been returned and no pulse has yet been applied for that byte.
- R12: After reset the transmit strobe is low. Each transmit request gets exactly one transmit strobe on the next cycle, and no strobe appears without a request. When nothing is due, the byte sent is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the control logic |
| bus_reset | input | 1 | Strobe: abort the current command |
| rx_valid | input | 1 | Strobe: a received byte is on rx_data |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Strobe: the host asks for one byte |
| tx_valid | output | 1 | Answer strobe, one cycle after tx_req |
| tx_data | output | 8 | Answer byte |
| prog_pulse | input | 1 | Strobe: apply programming to the pending byte |

## Verification
Some rules are checked on every cycle. Each transmit request gets exactly one answer on the next cycle. A bus reset always returns the engine to the command state. Each write to the store comes from a single pulse and is followed by the verify state. No data write ever lands in a page whose protect flag is cleared.

The bench scenarios cover behaviour that depends on values:
- the CRC values, including the masked-address case and the reseeded CRC after an address increment;
- the AND accumulation of repeated writes;
- stream lengths, and where the page CRCs and the end-of-data CRCs fall;
- the fixed status byte;
- pulses that land while no byte is pending.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam logic [7:0] CMD_WR_DATA = 8'h0F;
  localparam logic [7:0] CMD_WR_STAT = 8'h55;
  localparam logic [7:0] CMD_RD_DATA = 8'hF0;
  localparam logic [7:0] CMD_RD_PAGE = 8'hC3;
  localparam logic [7:0] CMD_RD_STAT = 8'hAA;

  typedef enum logic [3:0] {
    ST_CMD, ST_ADL, ST_ADH, ST_DATA, ST_HCRC,
    ST_PROG, ST_VFY, ST_READ, ST_TCRC, ST_ONES
  } eng_state_t;

  function automatic logic cmd_known(input logic [7:0] c);
    return c == CMD_WR_DATA || c == CMD_WR_STAT || c == CMD_RD_DATA ||
           c == CMD_RD_PAGE || c == CMD_RD_STAT;
  endfunction

  // Reflected form of x^8+x^5+x^4+1, bit 0 enters first.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 8'h8C;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/otp_crc8.sv
module otp_crc8 (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       shift,
  input  logic [7:0] shift_byte,
  output logic [7:0] crc
);
  import otp_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr)  crc <= 8'h00;
    else if (load)   crc <= load_val;
    else if (shift)  crc <= crc8_step(crc, shift_byte);
  end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DATA_BYTES = 128,
  parameter int STAT_BYTES = 8,
  parameter int NPAGES     = 4,
  localparam int AW = $clog2(DATA_BYTES),
  localparam int SW = $clog2(STAT_BYTES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              sel_stat,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wr_mask,
  output logic [7:0]        rd_data,
  output logic [NPAGES-1:0] wp_n
);
  logic [7:0] dmem [DATA_BYTES];
  logic [7:0] smem [STAT_BYTES];
  logic [SW-1:0] saddr;

  assign saddr = addr[SW-1:0];

  // Fuse-like cells: power up erased, never cleared by a logic reset.
  initial begin
    for (int i = 0; i < DATA_BYTES; i++) dmem[i] = 8'hFF;
    for (int i = 0; i < STAT_BYTES - 1; i++) smem[i] = 8'hFF;
    smem[STAT_BYTES-1] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !sel_stat)
      dmem[addr] <= dmem[addr] & wr_mask;
  end

  always_ff @(posedge clk) begin
    if (wr_en && sel_stat && saddr != SW'(STAT_BYTES - 1))
      smem[saddr] <= smem[saddr] & wr_mask;
  end

  assign rd_data = sel_stat ? smem[saddr] : dmem[addr];
  assign wp_n    = smem[0][NPAGES-1:0];
endmodule

// File: rtl/otp_cmd_engine.sv
module otp_cmd_engine #(
  parameter int DATA_BYTES = 128,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       prog_pulse
);
  import otp_pkg::*;

  localparam int AW     = $clog2(DATA_BYTES);
  localparam int SW     = $clog2(STAT_BYTES);
  localparam int PW     = $clog2(PAGE_BYTES);
  localparam int NPAGES = DATA_BYTES / PAGE_BYTES;
  localparam int PGW    = AW - PW;
  localparam logic [7:0] LO_MASK = 8'((1 << AW) - 1);

  eng_state_t        state_q;
  logic [7:0]        cmd_q, buf_q, crc_q, rd_byte;
  logic [AW-1:0]     addr_q, addr_inc;
  logic [SW-1:0]     s_next;
  logic              last_q, is_stat, is_wr, at_end, page_end, protect;
  logic [NPAGES-1:0] wp_n;
  logic              crc_clr, crc_load, crc_shift, st_wr_en;
  logic [7:0]        crc_in;

  assign is_stat  = (cmd_q == CMD_WR_STAT) || (cmd_q == CMD_RD_STAT);
  assign is_wr    = (cmd_q == CMD_WR_DATA) || (cmd_q == CMD_WR_STAT);
  assign s_next   = addr_q[SW-1:0] + SW'(1);
  assign addr_inc = is_stat ? AW'(s_next) : addr_q + AW'(1);
  assign at_end   = is_stat ? (addr_q[SW-1:0] == SW'(STAT_BYTES - 1))
                            : (addr_q == AW'(DATA_BYTES - 1));
  assign page_end = (addr_q[PW-1:0] == '1);
  assign protect  = !is_stat && !wp_n[addr_q[AW-1 -: PGW]];
  assign st_wr_en = (state_q == ST_PROG) && prog_pulse && !bus_reset && !protect;

  always_comb begin
    crc_clr   = bus_reset;
    crc_load  = 1'b0;
    crc_shift = 1'b0;
    crc_in    = rx_data;
    unique case (state_q)
      ST_CMD:  crc_shift = rx_valid;
      ST_ADL: begin
        crc_shift = rx_valid;
        if (cmd_q == CMD_WR_DATA) crc_in = rx_data & LO_MASK;
      end
      ST_ADH: begin
        crc_shift = rx_valid;
        if (cmd_q == CMD_WR_DATA) crc_in = 8'h00;
      end
      ST_DATA: crc_shift = rx_valid;
      ST_HCRC: crc_clr   = crc_clr | (tx_req && !is_wr);
      ST_VFY:  crc_load  = tx_req;
      ST_READ: begin
        crc_shift = tx_req;
        crc_in    = rd_byte;
      end
      ST_TCRC: crc_clr = crc_clr | tx_req;
      default: ;
    endcase
  end

  otp_crc8 i_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .load(crc_load),
    .load_val(8'(addr_inc)), .shift(crc_shift), .shift_byte(crc_in), .crc(crc_q)
  );

  otp_store #(.DATA_BYTES(DATA_BYTES), .STAT_BYTES(STAT_BYTES), .NPAGES(NPAGES)) i_store (
    .clk(clk), .wr_en(st_wr_en), .sel_stat(is_stat), .addr(addr_q),
    .wr_mask(buf_q), .rd_data(rd_byte), .wp_n(wp_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_CMD;
      cmd_q    <= 8'h00;
      addr_q   <= '0;
      buf_q    <= 8'hFF;
      last_q   <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= 8'hFF;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) tx_data <= 8'hFF;
      if (bus_reset) begin
        state_q <= ST_CMD;
      end else begin
        unique case (state_q)
          ST_CMD: if (rx_valid) begin
            cmd_q   <= rx_data;
            state_q <= cmd_known(rx_data) ? ST_ADL : ST_ONES;
          end
          ST_ADL: if (rx_valid) begin
            addr_q  <= is_stat ? AW'(rx_data[SW-1:0]) : rx_data[AW-1:0];
            state_q <= ST_ADH;
          end
          ST_ADH: if (rx_valid) begin
            last_q  <= 1'b0;
            state_q <= is_wr ? ST_DATA : ST_HCRC;
          end
          ST_DATA: if (rx_valid) begin
            buf_q   <= rx_data;
            state_q <= ST_HCRC;
          end
          ST_HCRC: if (tx_req) begin
            tx_data <= crc_q;
            state_q <= is_wr ? ST_PROG : ST_READ;
          end
          ST_PROG: if (prog_pulse) state_q <= ST_VFY;
          ST_VFY: if (tx_req) begin
            tx_data <= rd_byte;
            addr_q  <= addr_inc;
            state_q <= ST_DATA;
          end
          ST_READ: if (tx_req) begin
            tx_data <= rd_byte;
            addr_q  <= addr_inc;
            if (at_end) begin
              last_q  <= 1'b1;
              state_q <= ST_TCRC;
            end else if (cmd_q == CMD_RD_PAGE && page_end) begin
              state_q <= ST_TCRC;
            end
          end
          ST_TCRC: if (tx_req) begin
            tx_data <= crc_q;
            state_q <= last_q ? ST_ONES : ST_READ;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_cmd_checker.sv
module otp_cmd_checker #(
  parameter int AW     = 7,
  parameter int PGW    = 2,
  parameter int NPAGES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_reset,
  input logic              tx_req,
  input logic              tx_valid,
  input otp_pkg::eng_state_t state_q,
  input logic              wr_en,
  input logic              wr_stat,
  input logic [AW-1:0]     wr_addr,
  input logic [NPAGES-1:0] wp_n
);
  import otp_pkg::*;

  p_answer_next_r12: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> tx_valid);

  p_no_unasked_r12: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req));

  p_abort_to_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> state_q == ST_CMD);

  p_write_then_verify_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> state_q == ST_VFY);

  p_single_write_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  p_protected_page_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_stat) |-> wp_n[wr_addr[AW-1 -: PGW]]);
endmodule

bind otp_cmd_engine otp_cmd_checker #(.AW(AW), .PGW(PGW), .NPAGES(NPAGES)) i_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .tx_req(tx_req), .tx_valid(tx_valid),
  .state_q(state_q), .wr_en(st_wr_en), .wr_stat(is_stat), .wr_addr(addr_q), .wp_n(wp_n)
);

// File: tb/test_otp_cmd_engine.sv
`timescale 1ns/1ps
module test_otp_cmd_engine;
  logic clk = 0, rst = 1, bus_reset = 0, rx_valid = 0, tx_req = 0, prog_pulse = 0;
  logic [7:0] rx_data = 0, tx_data;
  logic tx_valid;
  int checks = 0, errors = 0;
  logic [7:0] mem_m [128];
  logic [7:0] stat_m [8];

  always #2.5 clk = ~clk;

  otp_cmd_engine i_otp_cmd_engine (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_data(tx_data), .prog_pulse(prog_pulse)
  );

  function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] s = c;
    for (int k = 0; k < 8; k++) begin
      logic fb = s[0] ^ b[k];
      s = {1'b0, s[7:1]};
      if (fb) s = s ^ 8'b1000_1100;
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic fetch(input string req, input logic [7:0] exp);
    @(negedge clk); tx_req = 1;
    @(negedge clk); tx_req = 0;
    chk({req, " strobe"}, {7'd0, tx_valid}, 8'h01);
    chk(req, tx_data, exp);
  endtask

  task automatic pulse();
    @(negedge clk); prog_pulse = 1;
    @(negedge clk); prog_pulse = 0;
  endtask

  task automatic abort();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic t_reset();
    chk("R12 reset strobe", {7'd0, tx_valid}, 8'h00);
    fetch("R12 idle answer", 8'hFF);
  endtask

  task automatic t_write_seq();
    logic [7:0] c;
    c = crc_b(crc_b(crc_b(crc_b(0, 8'h0F), 8'h05), 8'h00), 8'hA5);
    send(8'h0F); send(8'h05); send(8'h00); send(8'hA5);
    fetch("R1 write header crc", c);
    pulse(); mem_m[5] &= 8'hA5;
    fetch("R3 verify first", mem_m[5]);
    send(8'h3C);
    fetch("R4 reseeded crc", crc_b(8'h06, 8'h3C));
    pulse(); mem_m[6] &= 8'h3C;
    fetch("R4 verify next", mem_m[6]);
    abort();
    send(8'h0F); send(8'h05); send(8'h00); send(8'h0F);
    fetch("R1 second header", crc_b(crc_b(crc_b(crc_b(0, 8'h0F), 8'h05), 8'h00), 8'h0F));
    pulse(); mem_m[5] &= 8'h0F;
    fetch("R3 and accumulate", mem_m[5]);
    abort();
  endtask

  task automatic t_mask();
    send(8'h0F); send(8'h85); send(8'h01); send(8'hFE);
    fetch("R2 masked crc", crc_b(crc_b(crc_b(crc_b(0, 8'h0F), 8'h05), 8'h00), 8'hFE));
    pulse(); mem_m[5] &= 8'hFE;
    fetch("R2 masked target", mem_m[5]);
    abort();
  endtask

  task automatic t_nopend();
    send(8'h0F); send(8'h10); send(8'h00); send(8'h00);
    pulse();
    fetch("R11 crc after early pulse", crc_b(crc_b(crc_b(crc_b(0, 8'h0F), 8'h10), 8'h00), 8'h00));
    abort();
    pulse();
    send(8'hF0); send(8'h10); send(8'h00);
    fetch("R1 read header crc", crc_b(crc_b(crc_b(0, 8'hF0), 8'h10), 8'h00));
    fetch("R10 R11 cell untouched", 8'hFF);
    abort();
  endtask

  task automatic t_protect();
    send(8'h55); send(8'h00); send(8'h00); send(8'hFD);
    fetch("R1 status header crc", crc_b(crc_b(crc_b(crc_b(0, 8'h55), 8'h00), 8'h00), 8'hFD));
    pulse(); stat_m[0] &= 8'hFD;
    fetch("R3 status verify", stat_m[0]);
    abort();
    send(8'h0F); send(8'h25); send(8'h00); send(8'h00);
    fetch("R5 header", crc_b(crc_b(crc_b(crc_b(0, 8'h0F), 8'h25), 8'h00), 8'h00));
    pulse();
    fetch("R5 protected verify", 8'hFF);
    abort();
    send(8'hF0); send(8'h25); send(8'h00);
    fetch("R5 header read", crc_b(crc_b(crc_b(0, 8'hF0), 8'h25), 8'h00));
    fetch("R5 protected readable", 8'hFF);
    abort();
  endtask

  task automatic t_redirect();
    send(8'h55); send(8'h01); send(8'h00); send(8'hFD);
    fetch("R6 header", crc_b(crc_b(crc_b(crc_b(0, 8'h55), 8'h01), 8'h00), 8'hFD));
    pulse(); stat_m[1] &= 8'hFD;
    fetch("R6 redirect byte", stat_m[1]);
    send(8'h7F);
    fetch("R4 status reseed", crc_b(8'h02, 8'h7F));
    pulse(); stat_m[2] &= 8'h7F;
    fetch("R6 next status", stat_m[2]);
    abort();
    send(8'h55); send(8'h07); send(8'h00); send(8'hFF);
    fetch("R6 header b7", crc_b(crc_b(crc_b(crc_b(0, 8'h55), 8'h07), 8'h00), 8'hFF));
    pulse();
    fetch("R6 fixed byte", 8'h00);
    abort();
    send(8'h0F); send(8'h40); send(8'h00); send(8'h12);
    fetch("R6 header data", crc_b(crc_b(crc_b(crc_b(0, 8'h0F), 8'h40), 8'h00), 8'h12));
    pulse(); mem_m[8'h40] &= 8'h12;
    fetch("R6 redirect ignored", mem_m[8'h40]);
    abort();
  endtask

  task automatic t_read_status();
    logic [7:0] c = 0;
    send(8'hAA); send(8'h00); send(8'h00);
    fetch("R9 header", crc_b(crc_b(crc_b(0, 8'hAA), 8'h00), 8'h00));
    for (int i = 0; i < 8; i++) begin
      fetch("R9 status byte", stat_m[i]);
      c = crc_b(c, stat_m[i]);
    end
    fetch("R9 status crc", c);
    fetch("R9 trailing ones", 8'hFF);
    abort();
  endtask

  task automatic t_read_mem();
    logic [7:0] c = 0;
    send(8'hF0); send(8'h7C); send(8'h00);
    fetch("R7 header", crc_b(crc_b(crc_b(0, 8'hF0), 8'h7C), 8'h00));
    for (int i = 8'h7C; i < 128; i++) begin
      fetch("R7 data", mem_m[i]);
      c = crc_b(c, mem_m[i]);
    end
    fetch("R7 end crc", c);
    fetch("R7 ones", 8'hFF);
    fetch("R7 ones again", 8'hFF);
    abort();
  endtask

  task automatic t_page_crc();
    logic [7:0] c = 0;
    send(8'hC3); send(8'h3E); send(8'h00);
    fetch("R8 header", crc_b(crc_b(crc_b(0, 8'hC3), 8'h3E), 8'h00));
    for (int i = 8'h3E; i < 128; i++) begin
      fetch("R8 data", mem_m[i]);
      c = crc_b(c, mem_m[i]);
      if (i % 32 == 31) begin
        fetch("R8 page crc", c);
        c = 0;
      end
    end
    fetch("R8 ones", 8'hFF);
    abort();
  endtask

  task automatic t_bad_cmd();
    send(8'h12); send(8'h00);
    fetch("R1 unknown command", 8'hFF);
    abort();
    send(8'hF0); send(8'h7F); send(8'h00);
    fetch("R10 new command after abort", crc_b(crc_b(crc_b(0, 8'hF0), 8'h7F), 8'h00));
    abort();
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog actual hang expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem_m[i] = 8'hFF;
    for (int i = 0; i < 7; i++) stat_m[i] = 8'hFF;
    stat_m[7] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_seq();
    t_mask();
    t_nopend();
    t_protect();
    t_redirect();
    t_read_status();
    t_read_mem();
    t_page_crc();
    t_bad_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule